// File: doc/BRIEF.md
# Timed Four-Rail Power Sequencer

This controller switches the enables of four power rails on and off in an order set by per-rail delay values, counted in clock cycles. The rails start only after every undervoltage-OK flag, the enable input and a shared kill line have all been good for a qualification time. On-delay timers for all rails start together, and each rail's gate output rises when its own delay has passed. Once every gate is up and every rail reports fully on, a settle time runs. After it, the active-low power-good reset is released high.

Clearing the enable drops reset at once. The off-delay timers then start together, and each gate falls when its own off-delay has passed. An undervoltage flag that stays low for a filter time, while rails are being driven, is a fault. A fault clears all gates in one cycle, holds reset low and pulls the shared kill line low. The kill line is open-drain and wired-AND across several sequencers. When something outside the block holds it low, everything is forced off. When it is released and all inputs are already good, turn-on starts without the qualification wait. After a fault or a shutdown, the block starts again by itself once its inputs are satisfied.

States are IDLE, QUAL (qualification wait), RAMP_ON, SETTLE, RUN, RAMP_OFF and FAULT. The transitions are:
- IDLE→QUAL when ready.
- IDLE→RAMP_ON on a kill release while ready.
- QUAL→IDLE when ready drops.
- QUAL→RAMP_ON when the wait expires.
- RAMP_ON→SETTLE when all gates are up and all rails report on.
- SETTLE→RUN when the settle time expires.
- RAMP_ON, SETTLE or RUN→RAMP_OFF when enable drops.
- RAMP_OFF→IDLE when all gates are down and all rails report off.
- Any of RAMP_ON, SETTLE, RUN or RAMP_OFF→FAULT on a filtered fault.
- Any of RAMP_ON, SETTLE, RUN or RAMP_OFF→IDLE when the kill line is low.
- FAULT→IDLE when all undervoltage flags are good again.

Top module: `rail_sequencer`

## Requirements
- R1: Turn-on begins only after `uv_ok` (all ones), `en` and `kill_n_in` have been high on QUAL_CYC+1 consecutive clock edges. The gate with the smallest on-delay d rises exactly QUAL_CYC+d+1 cycles after the first edge that sees all inputs ready. If ready drops during the wait, no gate rises and the wait starts over.
- R2: All on-delay timers start together. The gate of rail i (delay in bits [i*DLY_W +: DLY_W] of `on_dly`) rises on-delay cycles after the sequence starts, so the gap between the rises of any two rails equals the difference of their on-delays.
- R3: `pwr_rst_n` stays low while any gate is low. It rises exactly SETTLE_CYC+1 cycles after the clock edge on which the last `rail_on` flag rises.
- R4: During RAMP_ON, SETTLE, RUN or RAMP_OFF, an undervoltage flag sampled low on FILT_CYC consecutive edges is a fault. On the edge FILT_CYC cycles after the first low sample, all gates fall, `pwr_rst_n` is low and `kill_drive` rises.
- R5: Clearing `en` drops `pwr_rst_n` on the next edge. Each gate then falls exactly off-delay+1 cycles after the reset falls, with the off-delay taken from the same bit slices of `off_dly`.
- R6: The kill line held low by an outside source forces all gates low and `pwr_rst_n` low on the next edge, from any state.
- R7: When an externally held kill line is released while all other inputs are good, the qualification wait is skipped. The first gate rises exactly d+2 cycles after the release is driven, where d is the smallest on-delay.
- R8: An undervoltage flag low on fewer than FILT_CYC consecutive edges has no effect: the gates and `pwr_rst_n` stay as they were.
- R9: After a fault, restoring every undervoltage flag releases `kill_drive` on the next edge. A full turn-on sequence, including the qualification wait, then follows without any other action.
- R10: `kill_drive` is high only in the fault state. It stays low during normal shutdown and during an outside kill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_ok | input | NUM_RAILS | Undervoltage-OK flag per rail, high when good |
| en | input | 1 | Sequencer enable, high to power up |
| kill_n_in | input | 1 | Level of the shared wired-AND kill line |
| kill_drive | output | 1 | Pull the kill line low (open-drain enable) |
| on_dly | input | NUM_RAILS*DLY_W | Packed per-rail turn-on delays in cycles |
| off_dly | input | NUM_RAILS*DLY_W | Packed per-rail turn-off delays in cycles |
| rail_on | input | NUM_RAILS | Rail reports fully on |
| rail_off | input | NUM_RAILS | Rail reports fully off |
| gate | output | NUM_RAILS | Rail enable outputs |
| pwr_rst_n | output | 1 | Active-low power-good reset |

## Verification
The hardest path to reach is the skip of the qualification wait. It needs the kill line held low by an outside source rather than by the block's own fault drive, while the enable and every undervoltage flag stay good. The bench models the wired-AND line as the outside level ANDed with the inverse of `kill_drive`. It pulls that level low while the block is in RUN and releases it a few cycles later, then times the first gate. The fault boundary is reached by holding one flag low for exactly FILT_CYC-1 samples and then for FILT_CYC samples, with the edge of the fault timed to the cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_QUAL,
        SQ_RAMP_ON,
        SQ_SETTLE,
        SQ_RUN,
        SQ_RAMP_OFF,
        SQ_FAULT
    } seq_state_e;
endpackage

// File: rtl/rseq_uv_filter.sv
module rseq_uv_filter #(
    parameter int FILT_CYC = 3750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ok,
    output logic fault
);
    localparam int FW = $clog2(FILT_CYC + 1);
    localparam logic [FW-1:0] FLIM = FW'(FILT_CYC);

    logic [FW-1:0] low_cnt;

    // count consecutive low samples; any good sample restarts the count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               low_cnt <= '0;
        else if (ok)              low_cnt <= '0;
        else if (low_cnt != FLIM) low_cnt <= low_cnt + 1'b1;
    end

    assign fault = (low_cnt == FLIM);

    AST_FLT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(!ok)); // R8
endmodule

// File: rtl/rseq_tick.sv
module rseq_tick #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // saturating phase counter, cleared on every state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
    import seq_pkg::*;
#(
    parameter int NUM_RAILS  = 4,
    parameter int DLY_W      = 8,
    parameter int QUAL_CYC   = 1250000,
    parameter int SETTLE_CYC = 20000000,
    parameter int FILT_CYC   = 3750
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_RAILS-1:0]       uv_ok,
    input  logic                       en,
    input  logic                       kill_n_in,
    output logic                       kill_drive,
    input  logic [NUM_RAILS*DLY_W-1:0] on_dly,
    input  logic [NUM_RAILS*DLY_W-1:0] off_dly,
    input  logic [NUM_RAILS-1:0]       rail_on,
    input  logic [NUM_RAILS-1:0]       rail_off,
    output logic [NUM_RAILS-1:0]       gate,
    output logic                       pwr_rst_n
);
    localparam int CNT_W = $clog2(QUAL_CYC + SETTLE_CYC + (1 << DLY_W) + 2);
    localparam logic [CNT_W-1:0] QUAL_LAST   = CNT_W'(QUAL_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

    seq_state_e st, st_nxt;
    logic [CNT_W-1:0]     tick;
    logic                 tick_clr;
    logic [NUM_RAILS-1:0] flt, hit_on, hit_off, gate_q, gate_d;
    logic                 any_flt, ready, active, kill_seen;

    // per-rail glitch filters and delay comparators
    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
        rseq_uv_filter #(.FILT_CYC(FILT_CYC)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .ok    (uv_ok[i]),
            .fault (flt[i])
        );
        assign hit_on[i]  = (tick >= CNT_W'(on_dly[i*DLY_W +: DLY_W]));
        assign hit_off[i] = (tick >= CNT_W'(off_dly[i*DLY_W +: DLY_W]));

        AST_GATE_RISE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_q[i]) |-> $past(hit_on[i])); // R2
    end

    rseq_tick #(.W(CNT_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .cnt   (tick)
    );

    assign any_flt  = |flt;
    assign ready    = (&uv_ok) & en & kill_n_in;
    assign active   = (st == SQ_RAMP_ON) || (st == SQ_SETTLE) ||
                      (st == SQ_RUN) || (st == SQ_RAMP_OFF);
    assign tick_clr = (st_nxt != st);

    // remembers that the kill line was held low from outside
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       kill_seen <= 1'b0;
        else if (!kill_n_in && !kill_drive) kill_seen <= 1'b1;
        else if (kill_n_in)               kill_seen <= 1'b0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        if (active && any_flt) begin
            st_nxt = SQ_FAULT;
        end else if (active && !kill_n_in) begin
            st_nxt = SQ_IDLE;
        end else begin
            unique case (st)
                SQ_IDLE: begin
                    if (kill_seen && ready) st_nxt = SQ_RAMP_ON;
                    else if (ready)         st_nxt = SQ_QUAL;
                end
                SQ_QUAL: begin
                    if (!ready)                  st_nxt = SQ_IDLE;
                    else if (tick == QUAL_LAST)  st_nxt = SQ_RAMP_ON;
                end
                SQ_RAMP_ON: begin
                    if (!en)                          st_nxt = SQ_RAMP_OFF;
                    else if ((&gate_q) && (&rail_on)) st_nxt = SQ_SETTLE;
                end
                SQ_SETTLE: begin
                    if (!en)                       st_nxt = SQ_RAMP_OFF;
                    else if (tick == SETTLE_LAST)  st_nxt = SQ_RUN;
                end
                SQ_RUN: begin
                    if (!en) st_nxt = SQ_RAMP_OFF;
                end
                SQ_RAMP_OFF: begin
                    if ((gate_q == '0) && (&rail_off)) st_nxt = SQ_IDLE;
                end
                SQ_FAULT: begin
                    if (&uv_ok) st_nxt = SQ_IDLE;
                end
                default: st_nxt = SQ_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        pwr_rst_n  = (st == SQ_RUN);
        kill_drive = (st == SQ_FAULT);
        gate       = gate_q;
        if ((st_nxt == SQ_IDLE) || (st_nxt == SQ_QUAL) || (st_nxt == SQ_FAULT))
            gate_d = '0;
        else if ((st == SQ_RAMP_ON) && (st_nxt == SQ_RAMP_ON))
            gate_d = gate_q | hit_on;
        else if ((st == SQ_RAMP_OFF) && (st_nxt == SQ_RAMP_OFF))
            gate_d = gate_q & ~hit_off;
        else
            gate_d = gate_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    AST_RST_NEEDS_ALL_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_rst_n |-> (&gate)); // R3
    AST_FAULT_FROM_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kill_drive) |-> $past(any_flt)); // R4
    AST_DISABLE_DROPS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwr_rst_n); // R5
    AST_EXT_KILL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!kill_n_in && !kill_drive) |=> ((gate == '0) && !pwr_rst_n)); // R6
    AST_DRIVE_ONLY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        kill_drive |-> ((gate == '0) && !pwr_rst_n)); // R10
endmodule

// File: tb/sim_rail_sequencer.sv
module sim_rail_sequencer;
    localparam int N = 4;
    localparam int DW = 3;
    localparam int QC = 6;
    localparam int SC = 5;
    localparam int FC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] uv_ok = '1;
    logic en = 1'b0;
    logic ext_n = 1'b1;
    logic kill_n_in, kill_drive, pwr_rst_n;
    logic [N*DW-1:0] on_dly = '0;
    logic [N*DW-1:0] off_dly = '0;
    logic [N-1:0] rail_q = '0;
    logic [N-1:0] gate;

    int n_chk = 0, n_err = 0, cyc = 0;
    int rise_t[N], fall_t[N];
    int rst_rise, rst_fall, oe_rise, oe_fall, oe_seen;
    int on_v[N], off_v[N];
    logic [N-1:0] g_prev = '0;
    logic r_prev = 1'b0, o_prev = 1'b0;

    always #4 clk = ~clk;

    assign kill_n_in = ext_n & ~kill_drive;

    rail_sequencer #(.NUM_RAILS(N), .DLY_W(DW), .QUAL_CYC(QC),
                     .SETTLE_CYC(SC), .FILT_CYC(FC)) u0 (
        .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .en(en),
        .kill_n_in(kill_n_in), .kill_drive(kill_drive),
        .on_dly(on_dly), .off_dly(off_dly),
        .rail_on(rail_q), .rail_off(~rail_q),
        .gate(gate), .pwr_rst_n(pwr_rst_n));

    // rail model: reports on/off one cycle after its gate
    always @(posedge clk) begin
        cyc <= cyc + 1;
        rail_q <= gate;
    end

    always @(negedge clk) if (rst_n) begin
        for (int i = 0; i < N; i++) begin
            if (gate[i] && !g_prev[i] && rise_t[i] < 0) rise_t[i] = cyc;
            if (!gate[i] && g_prev[i] && fall_t[i] < 0) fall_t[i] = cyc;
        end
        if (pwr_rst_n && !r_prev && rst_rise < 0) rst_rise = cyc;
        if (!pwr_rst_n && r_prev && rst_fall < 0) rst_fall = cyc;
        if (kill_drive && !o_prev && oe_rise < 0) oe_rise = cyc;
        if (!kill_drive && o_prev && oe_fall < 0) oe_fall = cyc;
        if (kill_drive) oe_seen = 1;
        g_prev = gate;
        r_prev = pwr_rst_n;
        o_prev = kill_drive;
    end

    task automatic clr_marks();
        for (int i = 0; i < N; i++) begin rise_t[i] = -1; fall_t[i] = -1; end
        rst_rise = -1; rst_fall = -1; oe_rise = -1; oe_fall = -1; oe_seen = 0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_pattern(input int p);
        for (int i = 0; i < N; i++) begin
            on_v[i]  = (p + 3 * i) % 8;
            off_v[i] = (5 * p + 3 * i + 1) % 8;
            on_dly[i*DW +: DW]  = DW'(on_v[i]);
            off_dly[i*DW +: DW] = DW'(off_v[i]);
        end
    endtask

    function automatic int min_on();
        int m = on_v[0];
        for (int i = 1; i < N; i++) if (on_v[i] < m) m = on_v[i];
        return m;
    endfunction

    function automatic int first_rise();
        int m = rise_t[0];
        for (int i = 1; i < N; i++) if (rise_t[i] < m) m = rise_t[i];
        return m;
    endfunction

    function automatic int last_rise();
        int m = rise_t[0];
        for (int i = 1; i < N; i++) if (rise_t[i] > m) m = rise_t[i];
        return m;
    endfunction

    task automatic wait_rst_high();
        int k = 0;
        while (!pwr_rst_n && k < 400) begin @(negedge clk); k++; end
        @(negedge clk);
    endtask

    task automatic wait_dark();
        int k = 0;
        while ((gate != '0 || rail_q != '0) && k < 400) begin @(negedge clk); k++; end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int c, m;
        clr_marks();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset gates", int'(gate), 0);
        chk("R3 reset pwr_rst_n", int'(pwr_rst_n), 0);
        chk("R10 reset kill_drive", int'(kill_drive), 0);

        // R1: interrupted wait never starts the ramp
        set_pattern(0);
        en = 1'b1;
        repeat (QC - 2) @(negedge clk);
        en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 aborted wait gates", int'(gate), 0);

        // sweep of delay patterns: turn-on then turn-off
        for (int p = 0; p < 8; p++) begin
            set_pattern(p);
            clr_marks();
            @(negedge clk);
            c = cyc;
            en = 1'b1;
            wait_rst_high();
            m = min_on();
            chk("R1 first gate after wait", first_rise() - (c + 1), QC + m + 1);
            for (int i = 1; i < N; i++)
                chk("R2 rise spacing", rise_t[i] - rise_t[0], on_v[i] - on_v[0]);
            chk("R3 settle before release", rst_rise - last_rise(), SC + 2);
            @(negedge clk);
            c = cyc;
            en = 1'b0;
            wait_dark();
            chk("R5 reset drops at once", rst_fall, c + 1);
            for (int i = 0; i < N; i++)
                chk("R5 off spacing", fall_t[i] - rst_fall, off_v[i] + 1);
            chk("R10 no drive in shutdown", oe_seen, 0);
        end

        // fault handling
        set_pattern(1);
        m = min_on();
        en = 1'b1;
        wait_rst_high();
        clr_marks();
        @(negedge clk);
        uv_ok[2] = 1'b0;
        repeat (FC - 1) @(negedge clk);
        uv_ok[2] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 short glitch gates", int'(gate), 15);
        chk("R8 short glitch reset", int'(pwr_rst_n), 1);
        chk("R8 short glitch drive", oe_seen, 0);

        clr_marks();
        @(negedge clk);
        c = cyc;
        uv_ok[1] = 1'b0;
        repeat (FC + 3) @(negedge clk);
        for (int i = 0; i < N; i++)
            chk("R4 gate drop edge", fall_t[i], c + 1 + FC);
        chk("R4 reset drop edge", rst_fall, c + 1 + FC);
        chk("R4 kill drive edge", oe_rise, c + 1 + FC);
        chk("R4 line pulled low", int'(kill_n_in), 0);

        clr_marks();
        @(negedge clk);
        c = cyc;
        uv_ok[1] = 1'b1;
        wait_rst_high();
        chk("R9 drive released", oe_fall, c + 1);
        chk("R9 restart with wait", first_rise() - c, QC + m + 3);

        // outside kill and release
        clr_marks();
        @(negedge clk);
        c = cyc;
        ext_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < N; i++)
            chk("R6 kill drops gate", fall_t[i], c + 1);
        chk("R6 kill drops reset", rst_fall, c + 1);
        chk("R10 no drive on outside kill", oe_seen, 0);

        clr_marks();
        @(negedge clk);
        c = cyc;
        ext_n = 1'b1;
        wait_rst_high();
        chk("R7 release skips wait", first_rise() - c, m + 2);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule